// File: doc/BRIEF.md
# Write-Once RAM Window Decoder

This block places an on-chip RAM array at a base address that software picks, and decides for every bus address whether the array is selected. A single 16-bit relocation register holds the upper address bits of the array's base. The register is reached through the chip's control-register window, and the array itself covers an aligned 8 KB window anywhere in a 24-bit address space.

After a master reset the array is disabled, and a read-only flag in the register reports this. The first bus write to the register, on either byte lane, loads the lanes it carries, enables the array and locks the register. From then on, further writes are still accepted on the bus but change nothing. Only another master reset reopens the register, so a runaway program cannot move the array. The control-register window decode takes no account of the array state, so software can always reach the relocation register.

The register port uses a valid/ready handshake. `bus_ready` is held high, so the block never applies back-pressure and every valid beat completes in the cycle it is presented. Read data is returned in that same cycle.

Top module: `ram_window_map`

## Requirements
- R1: After master reset the register reads 0x0001: a base field of zero, reserved bits zero and the disable flag (bit 0) set.
- R2: The first write to the register with at least one byte-enable set loads the enabled lanes into the base field (bits 15:5), clears the disable flag and sets the lock. Byte-enable bit 1 covers data bits 15:8 and bit 0 covers bits 7:0.
- R3: Once the lock is set, further register writes complete with `bus_ready` high and leave the read value unchanged until the next master reset.
- R4: A first write that enables only one lane still locks the register, so the other lane keeps its reset value of zero.
- R5: While the disable flag is set, `arr_hit` stays low for every address.
- R6: While the flag is clear, `arr_hit` is high exactly when `bus_addr[23:13]` equals the base field, bits 15:5 of the register.
- R7: `ctl_hit` is high exactly when `bus_addr[23:6]` equals the upper bits of the control window base (0x300000), whatever the array state. The register can be read through this window while the array is disabled.
- R8: Reserved bits 4:1 always read zero. Written values for bits 4:0 are ignored, and the disable flag cannot be written.
- R9: The register sits at byte address 0x300004 and is accessed only when `bus_addr[0]` is 0. `bus_rdata` carries the register value during a valid read of that address and is zero at any other time.
- R10: A write to the register with both byte-enables clear neither loads nor locks it.
- R11: `bus_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| bus_valid | input | 1 | Access request valid |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 24 | Byte address, used for both the register access and the array decode |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle |
| arr_hit | output | 1 | RAM array selected for `bus_addr` |
| ctl_hit | output | 1 | Control-register window selected for `bus_addr` |

## Verification
The hardest state to reach is a register that a partial first write has locked. It must then be probed with the opposite lane, and later reopened by a master reset so that a second first-write can happen. Directed steps write lane 0 alone, then attempt lane 1 and confirm that the array window moved only by the low lane's bits. The random phase issues master resets at intervals, so that many separate first-write events occur with random lanes, data and addresses. A quarter of the random addresses are aimed at the current window and at its edges, so that `arr_hit` is tested on both sides of every programmed base.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/rwm_ctl_decode.sv
module rwm_ctl_decode
  import ram_window_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CTL_LOG2 = 6,
  parameter logic [ADDR_W-1:0] CTL_BASE = 24'h30_0000,
  parameter int REG_OFS  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              write,
  input  logic              be_any,
  output logic              ctl_hit,
  output acc_e              reg_acc
);
  localparam int TAG_W = ADDR_W - CTL_LOG2;
  localparam logic [TAG_W-1:0] CTL_TAG = CTL_BASE[ADDR_W-1:CTL_LOG2];
  localparam logic [CTL_LOG2-1:0] OFS_V = CTL_LOG2'(REG_OFS);

  logic at_reg;

  // window decode never looks at the array state
  assign ctl_hit = (addr[ADDR_W-1:CTL_LOG2] == CTL_TAG);
  assign at_reg  = ctl_hit && (addr[CTL_LOG2-1:1] == OFS_V[CTL_LOG2-1:1]) && !addr[0];

  always_comb begin
    reg_acc = ACC_NONE;
    if (valid && at_reg) begin
      if (!write)      reg_acc = ACC_READ;
      else if (be_any) reg_acc = ACC_WRITE;
    end
  end
endmodule

// File: rtl/rwm_base_reg.sv
module rwm_base_reg
  import ram_window_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int BASE_W = 11
) (
  input  logic                    clk,
  input  logic                    mrst_n,
  input  logic                    wr_en,
  input  logic [REG_W/LANE_W-1:0] be,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        img_q,
  output logic                    dis_q,
  output logic                    locked_q
);
  localparam int LANES = REG_W / LANE_W;
  localparam logic [REG_W-1:0] FIELD_MASK = {{BASE_W{1'b1}}, {(REG_W-BASE_W){1'b0}}};

  logic [REG_W-1:0] lane_mask;
  logic [REG_W-1:0] wr_mask;
  logic             take;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
  end

  assign wr_mask = lane_mask & FIELD_MASK;
  assign take    = wr_en && !locked_q;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      img_q    <= '0;
      dis_q    <= 1'b1;
      locked_q <= 1'b0;
    end else if (take) begin
      img_q    <= (img_q & ~wr_mask) | (wdata & wr_mask);
      dis_q    <= 1'b0;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rwm_hit_cmp.sv
module rwm_hit_cmp #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 13
) (
  input  logic [ADDR_W-WIN_LOG2-1:0] addr_tag,
  input  logic [ADDR_W-WIN_LOG2-1:0] base,
  input  logic                       dis,
  output logic                       hit
);
  assign hit = !dis && (addr_tag == base);
endmodule

// File: rtl/ram_window_map.sv
module ram_window_map
  import ram_window_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 13,
  parameter int REG_W    = 16,
  parameter int CTL_LOG2 = 6,
  parameter logic [ADDR_W-1:0] CTL_BASE = 24'h30_0000,
  parameter int REG_OFS  = 4
) (
  input  logic                    clk,
  input  logic                    mrst_n,
  input  logic                    bus_valid,
  output logic                    bus_ready,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [REG_W/LANE_W-1:0] bus_be,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  output logic                    arr_hit,
  output logic                    ctl_hit
);
  localparam int BASE_W = ADDR_W - WIN_LOG2;

  acc_e             reg_acc;
  logic [REG_W-1:0] img_q;
  logic             dis_q;
  logic             locked_q;
  logic [REG_W-1:0] view;

  assign bus_ready = 1'b1;

  rwm_ctl_decode #(
    .ADDR_W(ADDR_W), .CTL_LOG2(CTL_LOG2), .CTL_BASE(CTL_BASE), .REG_OFS(REG_OFS)
  ) dec_i (
    .addr(bus_addr), .valid(bus_valid), .write(bus_write),
    .be_any(|bus_be), .ctl_hit(ctl_hit), .reg_acc(reg_acc)
  );

  rwm_base_reg #(.REG_W(REG_W), .BASE_W(BASE_W)) reg_i (
    .clk(clk), .mrst_n(mrst_n), .wr_en(reg_acc == ACC_WRITE),
    .be(bus_be), .wdata(bus_wdata),
    .img_q(img_q), .dis_q(dis_q), .locked_q(locked_q)
  );

  rwm_hit_cmp #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) cmp_i (
    .addr_tag(bus_addr[ADDR_W-1:WIN_LOG2]),
    .base(img_q[REG_W-1 -: BASE_W]),
    .dis(dis_q),
    .hit(arr_hit)
  );

  assign view      = img_q | {{(REG_W-1){1'b0}}, dis_q};
  assign bus_rdata = (reg_acc == ACC_READ) ? view : '0;
endmodule

// File: rtl/rwm_checker.sv
module rwm_checker #(
  parameter int REG_W  = 16,
  parameter int BASE_W = 11
) (
  input logic             clk,
  input logic             mrst_n,
  input logic [REG_W-1:0] img,
  input logic             dis,
  input logic             locked,
  input logic             arr_hit,
  input logic             ready,
  input logic [REG_W-1:0] rdata
);
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
    locked |=> locked);

  a_r2_enable_with_lock: assert property (@(posedge clk) disable iff (!mrst_n)
    $fell(dis) |-> $rose(locked));

  a_r3_frozen_after_lock: assert property (@(posedge clk) disable iff (!mrst_n)
    locked |=> $stable(img));

  a_r5_disabled_no_hit: assert property (@(posedge clk) disable iff (!mrst_n)
    dis |-> !arr_hit);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!mrst_n)
    rdata[REG_W-BASE_W-1:1] == '0);

  a_r11_never_stall: assert property (@(posedge clk) disable iff (!mrst_n)
    ready);
endmodule

bind ram_window_map rwm_checker #(.REG_W(REG_W), .BASE_W(BASE_W)) chk_i (
  .clk(clk), .mrst_n(mrst_n), .img(img_q), .dis(dis_q), .locked(locked_q),
  .arr_hit(arr_hit), .ready(bus_ready), .rdata(bus_rdata)
);

// File: tb/ram_window_map_tb_top.sv
`timescale 1ns/1ps
module ram_window_map_tb_top;
  localparam logic [23:0] REG_ADDR = 24'h30_0004;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ready, arr_hit, ctl_hit;
  logic [15:0] bus_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_img;
  logic        m_dis, m_lock;

  always #10 clk = ~clk;

  ram_window_map dut_i (
    .clk(clk), .mrst_n(mrst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_hit(arr_hit), .ctl_hit(ctl_hit)
  );

  function automatic logic [15:0] exp_view();
    return m_img | {15'd0, m_dis};
  endfunction

  function automatic logic exp_ctl(input logic [23:0] a);
    return a[23:6] == 18'(24'h30_0000 >> 6);
  endfunction

  function automatic logic at_reg(input logic [23:0] a);
    return exp_ctl(a) && a[5:1] == 5'd2 && !a[0];
  endfunction

  function automatic logic exp_arr(input logic [23:0] a);
    return !m_dis && a[23:13] == m_img[15:5];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic master_reset();
    @(negedge clk);
    mrst_n = 1'b0;
    bus_valid = 1'b0;
    m_img = '0; m_dis = 1'b1; m_lock = 1'b0;
    @(negedge clk);
    mrst_n = 1'b1;
  endtask

  // one bus beat: drive at negedge, check combinational outputs, commit model at edge
  task automatic beat(input logic v, input logic w, input logic [23:0] a,
                      input logic [1:0] be, input logic [15:0] d);
    logic [15:0] mask;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_be = be; bus_wdata = d;
    #1;
    check("R11", 32'(bus_ready), 32'd1);
    check("R7", 32'(ctl_hit), 32'(exp_ctl(a)));
    if (m_dis) check("R5", 32'(arr_hit), 32'd0);
    else       check("R6", 32'(arr_hit), 32'(exp_arr(a)));
    check("R9", 32'(bus_rdata), (v && !w && at_reg(a)) ? 32'(exp_view()) : 32'd0);
    if (v && w && at_reg(a) && |be && !m_lock) begin
      mask = {{8{be[1]}}, {8{be[0]}}} & 16'hFFE0;
      m_img = (m_img & ~mask) | (d & mask);
      m_dis = 1'b0;
      m_lock = 1'b1;
    end
  endtask

  task automatic read_reg(input string req, input logic [15:0] exp);
    beat(1'b1, 1'b0, REG_ADDR, 2'b00, 16'h0);
    check(req, 32'(bus_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    master_reset();
    // R1 reset value, array silent everywhere
    read_reg("R1", 16'h0001);
    beat(1'b0, 1'b0, 24'h00_0000, 2'b00, 16'h0);
    check("R1 hit", 32'(arr_hit), 32'd0);
    // R10 write without lanes does nothing
    beat(1'b1, 1'b1, REG_ADDR, 2'b00, 16'hFFFF);
    read_reg("R10", 16'h0001);
    // R9 misaligned write ignored
    beat(1'b1, 1'b1, REG_ADDR | 24'h1, 2'b11, 16'hFFFF);
    read_reg("R9", 16'h0001);
    // R4 partial write: low lane only, then high lane attempt
    beat(1'b1, 1'b1, REG_ADDR, 2'b01, 16'hFFFF);
    read_reg("R4", 16'h00E0);
    beat(1'b1, 1'b1, REG_ADDR, 2'b10, 16'hAB00);
    read_reg("R4", 16'h00E0);
    beat(1'b0, 1'b0, 24'h00_E000, 2'b00, 16'h0);
    check("R6 lo edge", 32'(arr_hit), 32'd1);
    // R2/R8 fresh full write with reserved/flag bits set in data
    master_reset();
    beat(1'b1, 1'b1, REG_ADDR, 2'b11, 16'hFFBF);
    read_reg("R8", 16'hFFA0);
    beat(1'b1, 1'b1, REG_ADDR, 2'b11, 16'h1234);
    read_reg("R3", 16'hFFA0);
    beat(1'b0, 1'b0, 24'hFF_A000, 2'b00, 16'h0);
    check("R6 base", 32'(arr_hit), 32'd1);
    beat(1'b0, 1'b0, 24'hFF_BFFF, 2'b00, 16'h0);
    check("R6 top", 32'(arr_hit), 32'd1);
    beat(1'b0, 1'b0, 24'hFF_9FFF, 2'b00, 16'h0);
    check("R6 below", 32'(arr_hit), 32'd0);
    beat(1'b0, 1'b0, 24'hFF_C000, 2'b00, 16'h0);
    check("R6 above", 32'(arr_hit), 32'd0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [23:0] a;
      if ($urandom % 200 == 0) master_reset();
      case ($urandom % 4)
        0: a = REG_ADDR;
        1: a = {18'(24'h30_0000 >> 6), 6'($urandom)};
        2: a = {m_img[15:5] + 11'($urandom % 3) - 11'd1, 13'($urandom)};
        default: a = 24'($urandom);
      endcase
      beat(1'($urandom), 1'($urandom), a, 2'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule